// File: doc/BRIEF.md
# Dual-Issue Load-Use Hazard and Bypass Unit

This block sits beside the decode stage of a five-stage, in-order integer pipeline that issues two instructions per cycle. Each cycle it compares every source register of the decode group against the destinations of the instructions now in execute and in memory. For each operand it picks a forwarding source. When the operand would have to come from a load that is still in execute, it raises a stall. It also finds the case where the younger decode slot needs a result from the older decode slot in the same group. In that case the younger slot waits one cycle and the older one proceeds.

The block is purely combinational and carries no state. Every pin is a plain control signal; no pin is a data stream. Back-pressure leaves the block as two signals. The stall freezes fetch and the whole decode group. The per-slot hold mask freezes only the younger slots. The bubble mask names the execute slots whose valid bits the pipeline clears on the next edge. Slot 0 is always the older instruction of a pair. The register file, the ALU and the operand multiplexers are outside this block.

Top module: `dual_issue_hazard_unit`

## Requirements
- R1: A forwarding match needs all of the following: a nonzero source register, a valid consuming decode slot, and a producer whose valid bit and register-write flag are both set. Register 0 never matches, even when a producer names it as its destination.
- R2: `stall` is 1 exactly when some valid decode operand takes its value from an execute-stage producer that is a load.
- R3: Each operand select uses this encoding: 0 for the register file, 1+k for execute slot k, and 1+NSLOT+k for memory slot k. With two slots that gives 1 and 2 for execute and 3 and 4 for memory. An ALU producer in execute gives its code with `stall` at 0.
- R4: A producer in the memory stage, whether a load or an ALU instruction, is forwarded (code 3 or 4) without a stall.
- R5: When producers in execute and in memory both match, the execute producer wins.
- R6: When two producers in the same stage both match, the lower-numbered (older) slot wins. This also decides whether a load-use stall occurs.
- R7: All four decode sources (rs1 and rs2 of both slots) are compared against both execute destinations and both memory destinations.
- R8: The younger decode slot depends on the older one when it reads the older slot's nonzero written destination and both slots are valid. It is then held: hold_mask bit 1 and bubble_mask bit 1 are set, while slot 0 is neither held nor bubbled.
- R9: During a stall, bubble_mask is all ones and hold_mask is all zeros.
- R10: A load followed at once by a dependent instruction costs exactly one stall cycle. In the next cycle the load sits in memory and execute holds a bubble, so the operand selects the memory slot and `stall` is 0.
- R11: An invalid decode slot never causes a stall or a hold, and its operand selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid | input | NSLOT | Decode slot holds an instruction |
| dec_wen | input | NSLOT | Decode slot writes a register |
| dec_rd | input | NSLOT×REG_W | Decode slot destination |
| dec_rs1 | input | NSLOT×REG_W | Decode slot first source |
| dec_rs2 | input | NSLOT×REG_W | Decode slot second source |
| ex_valid | input | NSLOT | Execute slot holds an instruction |
| ex_wen | input | NSLOT | Execute slot writes a register |
| ex_load | input | NSLOT | Execute slot is a load |
| ex_rd | input | NSLOT×REG_W | Execute slot destination |
| mem_valid | input | NSLOT | Memory slot holds an instruction |
| mem_wen | input | NSLOT | Memory slot writes a register |
| mem_rd | input | NSLOT×REG_W | Memory slot destination |
| stall | output | 1 | Freeze fetch and the decode group |
| bubble_mask | output | NSLOT | Execute slots to invalidate at the next edge |
| hold_mask | output | NSLOT | Decode slots held for a same-group dependency |
| fwd_sel_a | output | NSLOT×SEL_W | First-operand source select per slot |
| fwd_sel_b | output | NSLOT×SEL_W | Second-operand source select per slot |

## Verification
The hardest case to reach is the one-cycle load-use recovery. The stall ends only because the pipeline around the block moves the load into memory and places a bubble in execute, and the block sees none of this. The bench therefore plays the pipeline itself over two consecutive cycles: it keeps the same decode group, moves the load into the memory inputs and clears the execute inputs. It then expects a memory select with no stall. Priority ties are also set up on purpose, with an ALU result and a load aimed at the same register, so that the stall decision depends on which producer wins.

// File: rtl/dih_pkg.sv
package dih_pkg;
  localparam int DIH_SLOTS_DEF = 2;
  localparam int DIH_REG_W_DEF = 5;

  // select codes: 0 = register file, then execute slots, then memory slots
  function automatic int dih_sel_width(input int slots);
    return $clog2(2 * slots + 1);
  endfunction
endpackage

// File: rtl/dih_operand_resolver.sv
module dih_operand_resolver #(
  parameter int NSLOT = 2,
  parameter int REG_W = 5,
  parameter int SEL_W = 3
) (
  input  logic [REG_W-1:0]            src,
  input  logic                        live,
  input  logic [NSLOT-1:0]            ex_valid,
  input  logic [NSLOT-1:0]            ex_wen,
  input  logic [NSLOT-1:0]            ex_load,
  input  logic [NSLOT-1:0][REG_W-1:0] ex_rd,
  input  logic [NSLOT-1:0]            mem_valid,
  input  logic [NSLOT-1:0]            mem_wen,
  input  logic [NSLOT-1:0][REG_W-1:0] mem_rd,
  output logic [SEL_W-1:0]            sel,
  output logic                        load_hit
);
  logic [NSLOT-1:0] ex_hit;
  logic [NSLOT-1:0] mem_hit;

  // live already excludes register 0, so a zero destination never matches
  always_comb begin
    for (int k = 0; k < NSLOT; k++) begin
      ex_hit[k]  = live && ex_valid[k] && ex_wen[k] && (ex_rd[k] == src);
      mem_hit[k] = live && mem_valid[k] && mem_wen[k] && (mem_rd[k] == src);
    end
  end

  // lowest priority first; the last assignment wins
  always_comb begin
    sel      = '0;
    load_hit = 1'b0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (mem_hit[k]) begin
        sel      = SEL_W'(NSLOT + 1 + k);
        load_hit = 1'b0;
      end
    end
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (ex_hit[k]) begin
        sel      = SEL_W'(1 + k);
        load_hit = ex_load[k];
      end
    end
  end
endmodule

// File: rtl/dih_group_dep.sv
module dih_group_dep #(
  parameter int NSLOT = 2,
  parameter int REG_W = 5
) (
  input  logic [NSLOT-1:0]            dec_valid,
  input  logic [NSLOT-1:0]            dec_wen,
  input  logic [NSLOT-1:0][REG_W-1:0] dec_rd,
  input  logic [NSLOT-1:0][REG_W-1:0] dec_rs1,
  input  logic [NSLOT-1:0][REG_W-1:0] dec_rs2,
  output logic [NSLOT-1:0]            dep
);
  // a younger slot depends on any older slot of the same group
  always_comb begin
    dep = '0;
    for (int j = 1; j < NSLOT; j++) begin
      for (int i = 0; i < j; i++) begin
        if (dec_valid[j] && dec_valid[i] && dec_wen[i] && (dec_rd[i] != '0) &&
            ((dec_rs1[j] == dec_rd[i]) || (dec_rs2[j] == dec_rd[i])))
          dep[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_issue_hazard_unit.sv
module dual_issue_hazard_unit
  import dih_pkg::*;
#(
  parameter int NSLOT = DIH_SLOTS_DEF,
  parameter int REG_W = DIH_REG_W_DEF,
  localparam int SEL_W = dih_sel_width(NSLOT)
) (
  input  logic [NSLOT-1:0]            dec_valid,
  input  logic [NSLOT-1:0]            dec_wen,
  input  logic [NSLOT-1:0][REG_W-1:0] dec_rd,
  input  logic [NSLOT-1:0][REG_W-1:0] dec_rs1,
  input  logic [NSLOT-1:0][REG_W-1:0] dec_rs2,
  input  logic [NSLOT-1:0]            ex_valid,
  input  logic [NSLOT-1:0]            ex_wen,
  input  logic [NSLOT-1:0]            ex_load,
  input  logic [NSLOT-1:0][REG_W-1:0] ex_rd,
  input  logic [NSLOT-1:0]            mem_valid,
  input  logic [NSLOT-1:0]            mem_wen,
  input  logic [NSLOT-1:0][REG_W-1:0] mem_rd,
  output logic                        stall,
  output logic [NSLOT-1:0]            bubble_mask,
  output logic [NSLOT-1:0]            hold_mask,
  output logic [NSLOT-1:0][SEL_W-1:0] fwd_sel_a,
  output logic [NSLOT-1:0][SEL_W-1:0] fwd_sel_b
);
  logic [NSLOT-1:0] lu_a;
  logic [NSLOT-1:0] lu_b;
  logic [NSLOT-1:0] dep;
  logic [NSLOT-1:0] hold_raw;

  // one resolver per operand: NSLOT*2 sources against 2*NSLOT producers
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic live_a;
    logic live_b;
    assign live_a = dec_valid[s] && (dec_rs1[s] != '0);
    assign live_b = dec_valid[s] && (dec_rs2[s] != '0);

    dih_operand_resolver #(.NSLOT(NSLOT), .REG_W(REG_W), .SEL_W(SEL_W)) u_res_a (
      .src(dec_rs1[s]), .live(live_a),
      .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_load(ex_load), .ex_rd(ex_rd),
      .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_rd(mem_rd),
      .sel(fwd_sel_a[s]), .load_hit(lu_a[s])
    );

    dih_operand_resolver #(.NSLOT(NSLOT), .REG_W(REG_W), .SEL_W(SEL_W)) u_res_b (
      .src(dec_rs2[s]), .live(live_b),
      .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_load(ex_load), .ex_rd(ex_rd),
      .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_rd(mem_rd),
      .sel(fwd_sel_b[s]), .load_hit(lu_b[s])
    );
  end

  dih_group_dep #(.NSLOT(NSLOT), .REG_W(REG_W)) u_dep (
    .dec_valid(dec_valid), .dec_wen(dec_wen), .dec_rd(dec_rd),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dep(dep)
  );

  // once a slot is held, every younger slot waits with it
  always_comb begin
    hold_raw = '0;
    for (int j = 1; j < NSLOT; j++)
      hold_raw[j] = hold_raw[j-1] | dep[j];
  end

  assign stall       = |{lu_a, lu_b};
  assign hold_mask   = stall ? '0 : hold_raw;
  assign bubble_mask = stall ? '1 : hold_raw;
endmodule

// File: rtl/dih_checker.sv
module dih_checker
  import dih_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int REG_W = 5,
  localparam int SEL_W = dih_sel_width(NSLOT)
) (
  input logic [NSLOT-1:0]            dec_valid,
  input logic [NSLOT-1:0]            dec_wen,
  input logic [NSLOT-1:0][REG_W-1:0] dec_rd,
  input logic [NSLOT-1:0][REG_W-1:0] dec_rs1,
  input logic [NSLOT-1:0][REG_W-1:0] dec_rs2,
  input logic [NSLOT-1:0]            ex_valid,
  input logic [NSLOT-1:0]            ex_wen,
  input logic [NSLOT-1:0]            ex_load,
  input logic [NSLOT-1:0][REG_W-1:0] ex_rd,
  input logic [NSLOT-1:0]            mem_valid,
  input logic [NSLOT-1:0]            mem_wen,
  input logic [NSLOT-1:0][REG_W-1:0] mem_rd,
  input logic                        stall,
  input logic [NSLOT-1:0]            bubble_mask,
  input logic [NSLOT-1:0]            hold_mask,
  input logic [NSLOT-1:0][SEL_W-1:0] fwd_sel_a,
  input logic [NSLOT-1:0][SEL_W-1:0] fwd_sel_b
);
  always_comb begin
    p_stall_needs_ex_load_r2: assert (!stall || (|(ex_valid & ex_wen & ex_load)))
      else $error("stall without a load in execute");
    p_stall_bubbles_all_r9: assert (!stall || (bubble_mask == '1 && hold_mask == '0))
      else $error("stall did not bubble the whole group");
    p_oldest_not_held_r8: assert (!hold_mask[0] && !(stall == 1'b0 && bubble_mask[0]))
      else $error("oldest slot held without a stall");
    p_hold_is_bubbled_r8: assert ((hold_mask & ~bubble_mask) == '0)
      else $error("held slot not bubbled");
    for (int s = 0; s < NSLOT; s++) begin
      p_zero_src_reads_rf_r1: assert ((fwd_sel_a[s] == '0 || (dec_valid[s] && dec_rs1[s] != '0)) &&
                                      (fwd_sel_b[s] == '0 || (dec_valid[s] && dec_rs2[s] != '0)))
        else $error("forward on register 0 or invalid slot");
      p_sel_code_range_r3: assert (int'(fwd_sel_a[s]) <= 2 * NSLOT && int'(fwd_sel_b[s]) <= 2 * NSLOT)
        else $error("select code out of range");
    end
  end
endmodule

bind dual_issue_hazard_unit dih_checker #(.NSLOT(NSLOT), .REG_W(REG_W)) u_dih_chk (.*);

// File: tb/dual_issue_hazard_unit_tb.sv
module dual_issue_hazard_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0]      dec_valid, dec_wen, ex_valid, ex_wen, ex_load, mem_valid, mem_wen;
  logic [1:0][4:0] dec_rd, dec_rs1, dec_rs2, ex_rd, mem_rd;
  logic            stall;
  logic [1:0]      bubble_mask, hold_mask;
  logic [1:0][2:0] fwd_sel_a, fwd_sel_b;

  dual_issue_hazard_unit dut_i (.*);

  typedef struct {
    logic [16:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  // reference: execute 0, execute 1, memory 0, memory 1, then register file
  function automatic logic [2:0] ref_sel(input logic [4:0] src, input logic v);
    if (!v || src == 5'd0) return 3'd0;
    if (ex_valid[0] && ex_wen[0] && ex_rd[0] == src) return 3'd1;
    if (ex_valid[1] && ex_wen[1] && ex_rd[1] == src) return 3'd2;
    if (mem_valid[0] && mem_wen[0] && mem_rd[0] == src) return 3'd3;
    if (mem_valid[1] && mem_wen[1] && mem_rd[1] == src) return 3'd4;
    return 3'd0;
  endfunction

  function automatic bit is_lu(input logic [2:0] s);
    return (s == 3'd1 && ex_load[0]) || (s == 3'd2 && ex_load[1]);
  endfunction

  task automatic clear_all();
    dec_valid = '0; dec_wen = '0; dec_rd = '0; dec_rs1 = '0; dec_rs2 = '0;
    ex_valid = '0; ex_wen = '0; ex_load = '0; ex_rd = '0;
    mem_valid = '0; mem_wen = '0; mem_rd = '0;
  endtask

  // driver side: compute expected outputs from the current stimulus and queue them
  task automatic push(input string tag);
    logic [2:0] a0, a1, b0, b1;
    logic       st, dep1;
    logic [1:0] hold, bub;
    item_t      it;
    a0 = ref_sel(dec_rs1[0], dec_valid[0]);
    a1 = ref_sel(dec_rs1[1], dec_valid[1]);
    b0 = ref_sel(dec_rs2[0], dec_valid[0]);
    b1 = ref_sel(dec_rs2[1], dec_valid[1]);
    st = is_lu(a0) || is_lu(a1) || is_lu(b0) || is_lu(b1);
    dep1 = dec_valid[1] && dec_valid[0] && dec_wen[0] && dec_rd[0] != 5'd0 &&
           (dec_rs1[1] == dec_rd[0] || dec_rs2[1] == dec_rd[0]);
    hold = st ? 2'b00 : {dep1, 1'b0};
    bub  = st ? 2'b11 : hold;
    it.exp = {st, bub, hold, a1, a0, b1, b0};
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare away from the rising edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [16:0] act;
      it  = q.pop_front();
      act = {stall, bubble_mask, hold_mask, fwd_sel_a, fwd_sel_b};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    clear_all();
    @(posedge clk); push("R11 idle inputs give no hazard");

    @(posedge clk); clear_all();
    dec_valid = 2'b01; dec_rs1[0] = 5'd0;
    ex_valid = 2'b01; ex_wen = 2'b01; ex_load = 2'b01; ex_rd[0] = 5'd0;
    push("R1 register 0 never matches");

    @(posedge clk); clear_all();
    dec_valid = 2'b01; dec_rs1[0] = 5'd7; dec_rs2[0] = 5'd8;
    ex_valid = 2'b01; ex_wen = 2'b00; ex_rd[0] = 5'd7;
    ex_valid[1] = 1'b0; ex_wen[1] = 1'b1; ex_rd[1] = 5'd8;
    push("R1 producer needs valid and write flag");

    @(posedge clk); clear_all();
    dec_valid = 2'b01; dec_rs1[0] = 5'd5;
    ex_valid = 2'b01; ex_wen = 2'b01; ex_rd[0] = 5'd5;
    push("R3 ALU forward from execute slot 0");

    @(posedge clk); clear_all();
    dec_valid = 2'b10; dec_rs1[1] = 5'd10; dec_rs2[1] = 5'd9;
    ex_valid = 2'b11; ex_wen = 2'b11; ex_rd[0] = 5'd10; ex_rd[1] = 5'd9;
    push("R7 slot 1 sources against both execute slots");

    @(posedge clk); clear_all();
    dec_valid = 2'b11; dec_rs2[0] = 5'd12; dec_rs1[1] = 5'd13;
    mem_valid = 2'b11; mem_wen = 2'b11; mem_rd[0] = 5'd13; mem_rd[1] = 5'd12;
    push("R4 forward from memory slots");

    @(posedge clk); clear_all();
    dec_valid = 2'b01; dec_rs1[0] = 5'd6;
    ex_valid = 2'b10; ex_wen = 2'b10; ex_rd[1] = 5'd6;
    mem_valid = 2'b01; mem_wen = 2'b01; mem_rd[0] = 5'd6;
    push("R5 execute beats memory");

    @(posedge clk); clear_all();
    dec_valid = 2'b01; dec_rs2[0] = 5'd8;
    ex_valid = 2'b11; ex_wen = 2'b11; ex_load = 2'b10; ex_rd[0] = 5'd8; ex_rd[1] = 5'd8;
    push("R6 older ALU wins over younger load, no stall");

    @(posedge clk); clear_all();
    dec_valid = 2'b10; dec_rs1[1] = 5'd4;
    ex_valid = 2'b10; ex_wen = 2'b10; ex_load = 2'b10; ex_rd[1] = 5'd4;
    push("R2 load-use stall from execute slot 1");

    // two-cycle load-use recovery, pipeline moved by the bench
    @(posedge clk); clear_all();
    dec_valid = 2'b01; dec_rs1[0] = 5'd5;
    ex_valid = 2'b01; ex_wen = 2'b01; ex_load = 2'b01; ex_rd[0] = 5'd5;
    push("R10 first cycle stalls");
    @(posedge clk);
    ex_valid = 2'b00; ex_wen = 2'b00; ex_load = 2'b00; ex_rd = '0;
    mem_valid = 2'b01; mem_wen = 2'b01; mem_rd[0] = 5'd5;
    push("R10 second cycle forwards from memory");

    @(posedge clk); clear_all();
    dec_valid = 2'b11; dec_wen = 2'b01; dec_rd[0] = 5'd3; dec_rs2[1] = 5'd3;
    push("R8 younger slot held on older slot");

    @(posedge clk); clear_all();
    dec_valid = 2'b11; dec_wen = 2'b00; dec_rd[0] = 5'd3; dec_rs1[1] = 5'd3;
    push("R8 no hold when older slot does not write");

    @(posedge clk); clear_all();
    dec_valid = 2'b11; dec_wen = 2'b01; dec_rd[0] = 5'd0; dec_rs1[1] = 5'd0;
    push("R8 no hold on register 0");

    @(posedge clk); clear_all();
    dec_valid = 2'b01; dec_rs1[1] = 5'd4; dec_rs2[1] = 5'd4;
    ex_valid = 2'b01; ex_wen = 2'b01; ex_load = 2'b01; ex_rd[0] = 5'd4;
    push("R11 invalid slot ignored");

    @(posedge clk); clear_all();
    dec_valid = 2'b11; dec_wen = 2'b01; dec_rd[0] = 5'd2; dec_rs1[0] = 5'd11; dec_rs1[1] = 5'd2;
    ex_valid = 2'b01; ex_wen = 2'b01; ex_load = 2'b01; ex_rd[0] = 5'd11;
    push("R9 stall overrides hold");

    @(posedge clk); clear_all();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule